// File: doc/BRIEF.md
# Debounced Travel Edge Counter

This block measures travel from a single pulse train, for example one channel of a rotary position sensor, and raises a flag once a requested distance has been covered. The raw input is asynchronous to the clock, so it first crosses a chain of synchronizing flops. A debounce filter follows. The filter accepts a new level only after the synchronized input has held that level for a programmable number of clock cycles.

Both rising and falling transitions of the filtered level count as steps. The counter compares its value against half of the 9-bit distance request, which is the request with its lowest bit dropped. When a step arrives and the counter is no longer below that threshold, the arrival output goes high and the counter clears. Arrival then stays high until reset.

A distance request of zero stops all counting. A controller loads the request, watches the arrival output, and pulses reset before the next move.

Top module: `enc_travel_counter`

## Requirements
- R1: While reset is high, the arrival output is 0, and it drops to 0 as soon as reset rises, without waiting for a clock edge. Reset also clears the synchronizer, the filter, the transition history and the step counter.
- R2: The raw input passes through SYNC_STAGES flops (at least 2) before any other logic uses it. A transition is therefore never seen on the arrival output within 2 clock cycles of the raw change.
- R3: A level on the synchronized input that lasts fewer than DEBOUNCE_LIMIT cycles before reverting never changes the filtered level and is not counted.
- R4: A change of the filtered level in either direction, 0 to 1 or 1 to 0, counts as one step.
- R5: With the request nonzero and the step counter cleared, arrival rises on step number floor(request/2)+1. The threshold is request bits 8 down to 1.
- R6: While the request is 0, steps do not advance the counter, and steps seen then are not credited once a nonzero request returns.
- R7: Once high, the arrival output stays high through any further steps until reset.
- R8: A reset in the middle of a move discards all steps counted so far.
- R9: DEBOUNCE_LIMIT is a parameter with default 5000, which gives 100 µs of stability at a 50 MHz clock. SYNC_STAGES below 2 or a zero distance width is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| raw_in | input | 1 | Asynchronous pulse input |
| dist_req | input | DIST_W (9) | Requested travel; half of it sets the step threshold |
| arrived | output | 1 | Sticky flag: travel reached |

## Verification
Two functions can land in the same clock cycle: a step reaching the counter, and a change of the distance request to zero. The bench makes one step, drops the request to zero, makes several steps, and then restores the request. It checks that exactly the expected number of further steps is needed for arrival, so none of the inhibited steps were credited. A second coincidence, the step that both sets arrival and clears the counter, is judged by the sticky-flag check on the steps that follow.

// File: rtl/enc_travel_pkg.sv
package enc_travel_pkg;

   // Transition history: previous and current filtered sample
   typedef logic [1:0] hist_t;

   // A step is any history in which the two samples disagree
   function automatic logic is_step(input hist_t h);
      return h[1] ^ h[0];
   endfunction

endpackage

// File: rtl/enc_sync_chain.sv
module enc_sync_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("enc_sync_chain: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/enc_debounce.sv
module enc_debounce #(
   parameter int LIMIT = 5000
) (
   input  logic clk,
   input  logic rst,
   input  logic sync_i,
   output logic clean_o
);
   generate
      if (LIMIT == 0) begin : g_bypass
         // No filtering: the synchronized level is used directly
         assign clean_o = sync_i;
      end else begin : g_filter
         localparam int CW = $clog2(LIMIT + 1);
         localparam logic [CW-1:0] LIM = CW'(LIMIT);

         logic          prev_q;
         logic [CW-1:0] run_q;
         logic          clean_q;
         logic          held;

         assign held = (sync_i == prev_q);

         always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
               prev_q  <= 1'b0;
               run_q   <= '0;
               clean_q <= 1'b0;
            end else begin
               prev_q <= sync_i;
               if (!held)             run_q <= '0;
               else if (run_q != LIM) run_q <= run_q + 1'b1;
               if (held && run_q == LIM) clean_q <= sync_i;
            end
         end

         assign clean_o = clean_q;

         // R3
         run_bound_chk: assert property (@(posedge clk) disable iff (rst)
            run_q <= LIM);

         // R3
         no_change_on_toggle_chk: assert property (@(posedge clk) disable iff (rst)
            !$stable(sync_i) |=> $stable(clean_q));
      end
   endgenerate
endmodule

// File: rtl/enc_step_counter.sv
module enc_step_counter
   import enc_travel_pkg::*;
#(
   parameter int DIST_W = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clean_i,
   input  logic [DIST_W-1:0] dist_req_i,
   output logic              arrived_o
);
   localparam int TW = (DIST_W > 1) ? DIST_W - 1 : 1;

   hist_t          hist_q;
   logic [TW-1:0]  steps_q;
   logic [TW-1:0]  thresh;
   logic           arrived_q;
   logic           step;
   logic           enabled;

   generate
      if (DIST_W > 1) begin : g_half
         assign thresh = dist_req_i[DIST_W-1:1];
      end else begin : g_one
         assign thresh = '0;
      end
   endgenerate

   assign step    = is_step(hist_q);
   assign enabled = (dist_req_i != '0);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         hist_q    <= '0;
         steps_q   <= '0;
         arrived_q <= 1'b0;
      end else begin
         hist_q <= {hist_q[0], clean_i};
         if (enabled && step) begin
            if (steps_q < thresh) begin
               steps_q <= steps_q + 1'b1;
            end else begin
               steps_q   <= '0;
               arrived_q <= 1'b1;
            end
         end
      end
   end

   assign arrived_o = arrived_q;

   // R6
   zero_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (dist_req_i == '0) |=> $stable(steps_q) && $stable(arrived_q));

   // R7
   arrival_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      arrived_q |=> arrived_q);

   // R4
   step_needed_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(arrived_q) |-> $past(hist_q[1] != hist_q[0]));
endmodule

// File: rtl/enc_travel_counter.sv
module enc_travel_counter #(
   parameter int DIST_W         = 9,
   parameter int SYNC_STAGES    = 2,
   parameter int DEBOUNCE_LIMIT = 5000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              raw_in,
   input  logic [DIST_W-1:0] dist_req,
   output logic              arrived
);
   // R9
   generate
      if (DIST_W < 1) begin : g_bad_w
         $error("enc_travel_counter: DIST_W must be positive");
      end
      if (DEBOUNCE_LIMIT < 0) begin : g_bad_lim
         $error("enc_travel_counter: DEBOUNCE_LIMIT must not be negative");
      end
   endgenerate

   logic sync_lvl;
   logic clean_lvl;

   enc_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (raw_in),
      .q_o (sync_lvl)
   );

   enc_debounce #(.LIMIT(DEBOUNCE_LIMIT)) u_deb (
      .clk     (clk),
      .rst     (rst),
      .sync_i  (sync_lvl),
      .clean_o (clean_lvl)
   );

   enc_step_counter #(.DIST_W(DIST_W)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .clean_i    (clean_lvl),
      .dist_req_i (dist_req),
      .arrived_o  (arrived)
   );

   // R1
   reset_clears_chk: assert property (@(posedge clk)
      rst |-> !arrived);
endmodule

// File: tb/tb_enc_travel_counter.sv
module tb_enc_travel_counter;
   localparam int LIM  = 8;
   localparam int HOLD = LIM + 12;
   localparam int NV   = 7;
   localparam int REQ_TAB [NV] = '{1, 2, 4, 5, 9, 16, 511};
   localparam int EXP_TAB [NV] = '{1, 2, 3, 3, 5, 9, 256};

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       raw_in = 1'b0;
   logic [8:0] dist_req = '0;
   logic       arrived;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   enc_travel_counter #(.DIST_W(9), .SYNC_STAGES(2), .DEBOUNCE_LIMIT(LIM)) dut (
      .clk      (clk),
      .rst      (rst),
      .raw_in   (raw_in),
      .dist_req (dist_req),
      .arrived  (arrived)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: arrived=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic step_once();
      raw_in = ~raw_in;
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic glitch();
      raw_in = ~raw_in;
      repeat (3) @(negedge clk);
      raw_in = ~raw_in;
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      raw_in = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", arrived, 1'b0);
      rst = 1'b0;
      repeat (2) @(negedge clk);

      // R5 / R4: table of requests, both edge directions counted
      for (int v = 0; v < NV; v++) begin
         do_reset();
         dist_req = 9'(REQ_TAB[v]);
         for (int e = 1; e < EXP_TAB[v]; e++) step_once();
         check("R5", arrived, 1'b0);
         step_once();
         check("R4", arrived, 1'b1);
      end

      // R2: no arrival within 2 cycles of the final raw change
      do_reset();
      dist_req = 9'd2;
      step_once();
      raw_in = ~raw_in;
      repeat (2) @(negedge clk);
      check("R2", arrived, 1'b0);
      repeat (HOLD) @(negedge clk);
      check("R2", arrived, 1'b1);

      // R7: further steps leave arrival set
      step_once();
      step_once();
      step_once();
      check("R7", arrived, 1'b1);

      // R3: short pulses ignored
      do_reset();
      dist_req = 9'd1;
      for (int g = 0; g < 5; g++) glitch();
      check("R3", arrived, 1'b0);
      step_once();
      check("R3", arrived, 1'b1);

      // R6: zero request inhibits counting
      do_reset();
      dist_req = 9'd0;
      for (int e = 0; e < 6; e++) step_once();
      check("R6", arrived, 1'b0);

      // R6: step, then zero request in the same window as steps, then restore
      do_reset();
      dist_req = 9'd4;
      step_once();
      dist_req = 9'd0;
      step_once();
      step_once();
      step_once();
      dist_req = 9'd4;
      step_once();
      check("R6", arrived, 1'b0);
      step_once();
      check("R6", arrived, 1'b1);

      // R8: reset mid-travel discards progress
      do_reset();
      dist_req = 9'd4;
      step_once();
      step_once();
      do_reset();
      step_once();
      step_once();
      check("R8", arrived, 1'b0);
      step_once();
      check("R8", arrived, 1'b1);

      // R1: asynchronous clear, between clock edges
      @(negedge clk);
      #1 rst = 1'b1;
      #0.5 check("R1", arrived, 1'b0);
      repeat (2) @(negedge clk);
      rst = 1'b0;

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: timeout actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule